// File: doc/BRIEF.md
# Programmable interrupt mode router

This block takes interrupt activity from two card sockets and delivers it to the system in one of four delivery styles chosen by a 2-bit mode field. Each socket has two request inputs. The status request is always carried as a PCI-style interrupt. The card request is carried as a legacy ISA-style interrupt, and a 4-bit select per socket picks its IRQ number. Delivery can be on two parallel PCI lines, on parallel legacy IRQ lines, or as a request vector handed to a serial-IRQ frame encoder that sits outside this block.

The parallel lines leave the block through seven multifunction pins. A 4-bit routing code per pin decides what the pin carries. A pin that is not assigned to anything is left undriven. A tie bit folds the second socket's PCI interrupt onto the first line, so that the second pin can be used for another function. All outputs come from registers. Every output therefore reflects the inputs sampled at the previous rising clock edge and cannot glitch.

The block has no streaming data path. All ports are plain level signals with no handshake.

Top module: `irq_mode_router`

## Requirements
- R1: While `rst_n` is low, `pin_oe`, `pin_out`, `ser_irq` and `ser_pci` are all zero.
- R2: In mode 2'b00, PCI interrupts go out only on the parallel PCI pins. Legacy-assigned pins are driven low, and `ser_irq` and `ser_pci` are both zero.
- R3: In mode 2'b01, legacy IRQs are driven high on the pins assigned to them, and the PCI interrupts are also delivered in parallel.
- R4: In mode 2'b10, legacy IRQs appear only in `ser_irq`, where bit n is IRQ n. PCI interrupts stay on the parallel pins and `ser_pci` is zero.
- R5: In mode 2'b11, PCI interrupts appear only in `ser_pci` (bit 0 is INTA, bit 1 is INTB) and legacy IRQs appear only in `ser_irq`. The parallel PCI pins are not driven and the legacy pins are driven low.
- R6: Pin k is configured by `pin_code[4k+3:4k]`. Code 1 on pin 0 carries INTA, which is socket A's status request. Code 1 on pin 1 carries INTB, which is socket B's status request. INTA and INTB appear on no other pin.
- R7: When `int_tie` is 1, INTA is pending if either socket's status request is pending, and INTB is never pending.
- R8: A pin whose code is 0, or a pin numbered 2 or higher whose code is 1, has `pin_oe` low and `pin_out` low.
- R9: A pending card request with select n, where n is from 2 to 15, raises IRQ n. Selects 0 and 1 are reserved and raise nothing. Two sockets on the same IRQ are OR-ed together.
- R10: A change on any input, including the mode, shows on the outputs after exactly one rising clock edge.
- R11: A pin with code 2 to 15 is always driven (`pin_oe` high), with `pin_out` set to the parallel level of the IRQ whose number equals the code. A PCI pin is driven only while its interrupt is pending, and its `pin_out` is then low, which gives active-low open-drain behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Delivery mode |
| int_tie | input | 1 | Fold INTB onto INTA |
| stat_req | input | 2 | Status request per socket (bit 0 = socket A) |
| card_req | input | 2 | Card (legacy) request per socket |
| irq_sel_a | input | 4 | IRQ number for socket A's card request |
| irq_sel_b | input | 4 | IRQ number for socket B's card request |
| pin_code | input | 28 | Routing code per multifunction pin, 4 bits each |
| pin_out | output | 7 | Pin drive level |
| pin_oe | output | 7 | Pin output enable |
| ser_irq | output | 16 | Legacy request vector for the serial encoder |
| ser_pci | output | 2 | PCI request vector for the serial encoder |

## Verification
The in-line assertions check the following on every clock:
- The serial vectors are silent in parallel-only mode.
- `ser_pci` is zero in mode 2'b10.
- The PCI pins are never driven high and go quiet in full-serial mode.
- Unassigned pins stay undriven.
- A tied INTB pin never asserts.
- Reserved selects raise no IRQ.

Other behaviour can only be shown by the bench's scenarios:
- That the correct IRQ number lands on the correct pin or vector bit.
- That each mode sends each class of interrupt to the right place.
- That two sockets sharing an IRQ are OR-ed.
- That back-to-back mode changes take effect after exactly one edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  typedef enum logic [1:0] {
    DLV_PAR_PCI    = 2'b00,
    DLV_PAR_ALL    = 2'b01,
    DLV_SER_LEGACY = 2'b10,
    DLV_SER_ALL    = 2'b11
  } dlv_mode_e;

  localparam int unsigned CODE_W  = 4;
  localparam int unsigned IRQ_N   = 1 << CODE_W;
  localparam int unsigned IRQ_MIN = 2;
  localparam logic [CODE_W-1:0] CODE_NONE = '0;
  localparam logic [CODE_W-1:0] CODE_PCI  = CODE_W'(1);
endpackage

// File: rtl/irq_num_decode.sv
module irq_num_decode
  import irq_route_pkg::*;
(
  input  logic              req,
  input  logic [CODE_W-1:0] sel,
  output logic [IRQ_N-1:0]  vec
);
  always_comb begin
    vec = '0;
    if (req && (sel >= CODE_W'(IRQ_MIN))) vec[sel] = 1'b1;
  end
endmodule

// File: rtl/pci_line_merge.sv
module pci_line_merge
  import irq_route_pkg::*;
(
  input  logic [1:0] stat,
  input  logic       tie,
  input  dlv_mode_e  mode,
  output logic [1:0] par,
  output logic [1:0] ser
);
  logic [1:0] line;
  always_comb begin
    line[0] = stat[0] | (tie & stat[1]);
    line[1] = stat[1] & ~tie;
    par = (mode == DLV_SER_ALL) ? 2'b00 : line;
    ser = (mode == DLV_SER_ALL) ? line : 2'b00;
  end
endmodule

// File: rtl/pin_route.sv
module pin_route
  import irq_route_pkg::*;
#(
  parameter bit HAS_PCI = 1'b0
) (
  input  logic [CODE_W-1:0] code,
  input  logic              pci_bit,
  input  logic [IRQ_N-1:0]  irq_lvl,
  output logic              drv,
  output logic              oe
);
  always_comb begin
    drv = 1'b0;
    oe  = 1'b0;
    if (code == CODE_PCI) begin
      oe = HAS_PCI & pci_bit;
    end else if (code != CODE_NONE) begin
      oe  = 1'b1;
      drv = irq_lvl[code];
    end
  end
endmodule

// File: rtl/irq_mode_router.sv
module irq_mode_router
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_PINS = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 mode,
  input  logic                       int_tie,
  input  logic [1:0]                 stat_req,
  input  logic [1:0]                 card_req,
  input  logic [CODE_W-1:0]          irq_sel_a,
  input  logic [CODE_W-1:0]          irq_sel_b,
  input  logic [NUM_PINS*CODE_W-1:0] pin_code,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS-1:0]        pin_oe,
  output logic [IRQ_N-1:0]           ser_irq,
  output logic [1:0]                 ser_pci
);
  dlv_mode_e mode_e;
  assign mode_e = dlv_mode_e'(mode);

  logic [CODE_W-1:0] sel_arr [2];
  logic [IRQ_N-1:0]  dec_vec [2];
  assign sel_arr[0] = irq_sel_a;
  assign sel_arr[1] = irq_sel_b;

  for (genvar s = 0; s < 2; s++) begin : g_sock
    irq_num_decode u_dec (.req(card_req[s]), .sel(sel_arr[s]), .vec(dec_vec[s]));
  end

  logic [IRQ_N-1:0] req_vec, irq_lvl, ser_irq_d;
  always_comb begin
    req_vec   = dec_vec[0] | dec_vec[1];
    irq_lvl   = (mode_e == DLV_PAR_ALL) ? req_vec : '0;
    ser_irq_d = mode[1] ? req_vec : '0;
  end

  logic [1:0] pci_par, ser_pci_d;
  pci_line_merge u_merge (
    .stat(stat_req), .tie(int_tie), .mode(mode_e), .par(pci_par), .ser(ser_pci_d)
  );

  logic [NUM_PINS-1:0] pci_pad, drv_d, oe_d, unused_mask;
  assign pci_pad = NUM_PINS'(pci_par);

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    pin_route #(.HAS_PCI(k < 2)) u_pin (
      .code(pin_code[k*CODE_W +: CODE_W]), .pci_bit(pci_pad[k]),
      .irq_lvl(irq_lvl), .drv(drv_d[k]), .oe(oe_d[k])
    );
    assign unused_mask[k] = (pin_code[k*CODE_W +: CODE_W] == CODE_NONE) ||
                            ((k >= 2) && (pin_code[k*CODE_W +: CODE_W] == CODE_PCI));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_out <= '0;
      pin_oe  <= '0;
      ser_irq <= '0;
      ser_pci <= '0;
    end else begin
      pin_out <= drv_d;
      pin_oe  <= oe_d;
      ser_irq <= ser_irq_d;
      ser_pci <= ser_pci_d;
    end
  end

  a_r2_par_mode_serial_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (ser_irq == '0 && ser_pci == 2'b00));

  a_r4_mixed_mode_no_ser_pci: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (ser_pci == 2'b00));

  a_r5_full_serial_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && pin_code[CODE_W-1:0] == CODE_PCI) |=> !pin_oe[0]);

  a_r11_pci_pin_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_code[CODE_W-1:0] == CODE_PCI) |=> !pin_out[0]);

  a_r8_unused_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (|unused_mask) |=> ((pin_oe & $past(unused_mask)) == '0));

  a_r7_tied_intb_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (int_tie && pin_code[CODE_W +: CODE_W] == CODE_PCI) |=> !pin_oe[1]);

  a_r9_reserved_select_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sel_a < CODE_W'(IRQ_MIN) && irq_sel_b < CODE_W'(IRQ_MIN)) |=> (ser_irq == '0));
endmodule

// File: tb/irq_mode_router_bench.sv
module irq_mode_router_bench;
  localparam int NP = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic int_tie = 1'b0;
  logic [1:0] stat_req = 2'b00, card_req = 2'b00;
  logic [3:0] irq_sel_a = 4'd0, irq_sel_b = 4'd0;
  logic [NP*4-1:0] pin_code = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [15:0] ser_irq;
  logic [1:0] ser_pci;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_mode_router u_irq_mode_router (
    .clk(clk), .rst_n(rst_n), .mode(mode), .int_tie(int_tie),
    .stat_req(stat_req), .card_req(card_req), .irq_sel_a(irq_sel_a),
    .irq_sel_b(irq_sel_b), .pin_code(pin_code), .pin_out(pin_out),
    .pin_oe(pin_oe), .ser_irq(ser_irq), .ser_pci(ser_pci)
  );

  function automatic logic [31:0] model(logic [1:0] m, logic t, logic [1:0] st,
      logic [1:0] cd, logic [3:0] sa, logic [3:0] sb, logic [NP*4-1:0] codes);
    logic [15:0] rv, lvl, sirq;
    logic [1:0] ln, ppar, spci;
    logic [NP-1:0] oe, dv;
    rv = '0;
    if (cd[0] && sa >= 2) rv[sa] = 1'b1;
    if (cd[1] && sb >= 2) rv[sb] = 1'b1;
    ln[0] = st[0] | (t & st[1]);
    ln[1] = st[1] & ~t;
    ppar = (m == 2'b11) ? 2'b00 : ln;
    spci = (m == 2'b11) ? ln : 2'b00;
    lvl  = (m == 2'b01) ? rv : '0;
    sirq = m[1] ? rv : '0;
    oe = '0; dv = '0;
    for (int k = 0; k < NP; k++) begin
      logic [3:0] c;
      c = codes[k*4 +: 4];
      if (c == 4'd1) begin
        if (k < 2) oe[k] = ppar[k];
      end else if (c != 4'd0) begin
        oe[k] = 1'b1;
        dv[k] = lvl[c];
      end
    end
    return {oe, dv, sirq, spci};
  endfunction

  task automatic drive(input logic [1:0] m, input logic t, input logic [1:0] st,
      input logic [1:0] cd, input logic [3:0] sa, input logic [3:0] sb,
      input logic [NP*4-1:0] codes, input string tag);
    @(negedge clk);
    mode = m; int_tie = t; stat_req = st; card_req = cd;
    irq_sel_a = sa; irq_sel_b = sb; pin_code = codes;
    exp_q.push_back(model(m, t, st, cd, sa, sb, codes));
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      logic [31:0] e, a;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      a = {pin_oe, pin_out, ser_irq, ser_pci};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", tg, a, e);
      end
    end
  end

  // pin k code: pin0=1 pin1=1 pin2=5 pin3=9 pin4=0 pin5=1 pin6=15
  localparam logic [NP*4-1:0] BASE = {4'd15, 4'd1, 4'd0, 4'd9, 4'd5, 4'd1, 4'd1};
  localparam logic [NP*4-1:0] ALT  = {4'd15, 4'd1, 4'd0, 4'd9, 4'd5, 4'd0, 4'd5};

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if ({pin_oe, pin_out, ser_irq, ser_pci} !== 32'd0) begin
      bad++;
      $display("FAIL R1 actual=%h expected=0", {pin_oe, pin_out, ser_irq, ser_pci});
    end
    rst_n = 1'b1;
    drive(2'b00, 0, 2'b11, 2'b11, 4'd5, 4'd9, BASE, "R2 parallel PCI only");
    drive(2'b01, 0, 2'b11, 2'b11, 4'd5, 4'd9, BASE, "R3 all parallel / R10 mode step");
    drive(2'b10, 0, 2'b11, 2'b11, 4'd5, 4'd9, BASE, "R4 serial legacy");
    drive(2'b11, 0, 2'b11, 2'b11, 4'd5, 4'd9, BASE, "R5 full serial");
    drive(2'b00, 1, 2'b10, 2'b00, 4'd5, 4'd9, BASE, "R7 tie parallel");
    drive(2'b11, 1, 2'b10, 2'b00, 4'd5, 4'd9, BASE, "R7 tie serial");
    drive(2'b01, 0, 2'b00, 2'b11, 4'd1, 4'd0, BASE, "R9 reserved selects");
    drive(2'b01, 0, 2'b00, 2'b11, 4'd15, 4'd15, BASE, "R9 shared IRQ15");
    drive(2'b10, 0, 2'b00, 2'b10, 4'd2, 4'd3, BASE, "R9 socket B only IRQ3");
    drive(2'b00, 0, 2'b11, 2'b00, 4'd5, 4'd9, ALT, "R6 PCI not on reassigned pins");
    drive(2'b01, 0, 2'b11, 2'b01, 4'd5, 4'd9, ALT, "R11 legacy code on pin0");
    drive(2'b00, 0, 2'b00, 2'b00, 4'd5, 4'd9, BASE, "R11 idle PCI undriven");
    drive(2'b01, 0, 2'b01, 2'b01, 4'd9, 4'd0, BASE, "R8 unused pins / R10");
    drive(2'b10, 0, 2'b10, 2'b01, 4'd9, 4'd0, BASE, "R10 back-to-back change");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule